// File: doc/BRIEF.md
# Machine Cycle Sequencer for an 8-bit CPU

This block steps an 8-bit processor through the timing states of its bus activity. An instruction is a run of one to five machine cycles, and each machine cycle is a run of three to five timing states. The block adds a wait state when memory is slow, a halt state after a halt instruction, and a hold state when an external master asks for the bus. The instruction decoder supplies a descriptor for the instruction in progress. The descriptor gives the cycle count, the kind of each later cycle, the state count of each cycle, and the condition fields. The decoder keeps the descriptor stable from the first timing state of the instruction until its last.

The block reports the current machine cycle and timing state. It raises a one-clock strobe at the start of every cycle that uses the bus, together with a status code for that cycle. It also drives a hold acknowledge, a halt flag, and a code that tells the address path which source to place on the address lines.

Top module: `mcycle_seq`

## Requirements
- R1: A synchronous reset puts the block in machine cycle 1, state T1, with `hold_ack` and `halted` low. The first cycle after reset is an opcode fetch from the program counter.
- R2: Every machine cycle steps T1, T2, T3 (`t_state` codes 1 to 3). Cycle k runs to state 3+c, where c is field `d_len[2k-1:2k-2]`, and a field value of 3 counts as 5 states. The next cycle is M(k+1). After cycle `d_ncyc`, or after cycle `NUM_M`, the next cycle is M1.
- R3: `sync` is high only in T1 of cycles that use the bus. `status` is 0 unless `sync` is high. M1 reports fetch 1, or interrupt acknowledge 8. A later cycle of type code y in 1..6 (from `d_type[3k-4:3k-6]` for cycle k) reports y+1. Type codes: 1 memory read, 2 memory write, 3 stack read, 4 stack write, 5 input, 6 output.
- R4: In T2 of a bus cycle, a low `ready` sends the block to the wait state (code 6). The block stays there while `ready` is low and moves to T3 on the clock after `ready` is high.
- R5: A cycle of type 0 or 7 is internal. It raises no `sync` and ignores `ready`. While `hold_req` is high from T1 onward, `hold_ack` goes high from the next state to the end of the cycle, with `addr_sel` = 4 (released).
- R6: If `d_cond` is high and `d_cond_ok` is low, the instruction ends after M1 when `d_skip_hi` is 0, or after M3 when it is 1. The next cycle is M1.
- R7: The M1 after an instruction with `d_xfer` high, and with its condition not failed, drives `addr_sel` = 1 (temporary pair). Otherwise M1 drives 0 (program counter).
- R8: Input and output cycles drive `addr_sel` = 2 (port number on both address bytes).
- R9: After M1 of an instruction with `d_halt` high, M2 is a halt acknowledge cycle: T1 with `sync` and status 9, then T2. The block then enters the halt state (code 7) with `halted` high, and stays there without an interrupt or hold.
- R10: An `int_req` that is high in the halt state, or at the last state of an instruction, makes the next M1 an interrupt acknowledge fetch (status 8, `addr_sel` 0).
- R11: A `hold_req` that is high at the end of a machine cycle gives the hold state (code 0), with `hold_ack` high and `addr_sel` = 4. When `hold_req` drops, the block resumes at T1 of the pending cycle. A hold taken from the halt state keeps `halted` high and returns to the halt state.
- R12: Memory read cycles drive `addr_sel` = 0. Memory write, stack read and stack write cycles drive 3 (decoder-chosen data pointer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready | input | 1 | Memory ready, sampled in T2 and in wait |
| hold_req | input | 1 | Bus hold request |
| int_req | input | 1 | Interrupt request |
| d_ncyc | input | MW | Machine cycles in the instruction (1..NUM_M) |
| d_len | input | 2*NUM_M | Per-cycle state count code, cycle 1 in the low bits |
| d_type | input | 3*(NUM_M-1) | Per-cycle type for M2 upward |
| d_cond | input | 1 | Instruction is conditional |
| d_cond_ok | input | 1 | Condition result |
| d_skip_hi | input | 1 | Failed condition ends after M3 instead of M1 |
| d_xfer | input | 1 | Next fetch takes its address from the temporary pair |
| d_halt | input | 1 | Instruction is a halt |
| m_state | output | MW | Current machine cycle, 1-based |
| t_state | output | 3 | 0 hold, 1..5 T1..T5, 6 wait, 7 halt |
| sync | output | 1 | Start-of-bus-cycle strobe |
| status | output | 4 | Cycle type code, valid with sync |
| hold_ack | output | 1 | Bus released to an external master |
| halted | output | 1 | Halt state, including hold taken from halt |
| addr_sel | output | 3 | 0 PC, 1 temporary pair, 2 port, 3 data pointer, 4 released |

## Verification
The bench builds the block with the default `NUM_M` of 5. This brings within reach the late skip that drops M4 and M5, the end of an instruction at cycle 5, and the three-bit cycle counter wrapping back to M1. Every two-bit state-count code is exercised, including the value that saturates at five states. Random descriptors mix with random `ready`, hold and interrupt traffic, so waits, holds and interrupts land in every kind of cycle.

// File: rtl/mcycle_seq.sv
module mcycle_seq #(
  parameter int NUM_M = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ready,
  input  logic                       hold_req,
  input  logic                       int_req,
  input  logic [$clog2(NUM_M+1)-1:0] d_ncyc,
  input  logic [2*NUM_M-1:0]         d_len,
  input  logic [3*(NUM_M-1)-1:0]     d_type,
  input  logic                       d_cond,
  input  logic                       d_cond_ok,
  input  logic                       d_skip_hi,
  input  logic                       d_xfer,
  input  logic                       d_halt,
  output logic [$clog2(NUM_M+1)-1:0] m_state,
  output logic [2:0]                 t_state,
  output logic                       sync,
  output logic [3:0]                 status,
  output logic                       hold_ack,
  output logic                       halted,
  output logic [2:0]                 addr_sel
);
  localparam int MW = $clog2(NUM_M + 1);
  localparam logic [2:0] S_HOLD = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_T3 = 3'd3,
                         S_WAIT = 3'd6, S_HALT = 3'd7;
  localparam logic [3:0] K_INT = 4'd0, K_FETCH = 4'd1, K_INTA = 4'd8, K_HALT = 4'd9;
  localparam logic [2:0] A_PC = 3'd0, A_WZ = 3'd1, A_PORT = 3'd2, A_PTR = 3'd3, A_HIZ = 3'd4;

  logic [MW-1:0] m, m_n;
  logic [2:0] t, t_n, ty, last_t;
  logic [1:0] ln;
  logic [3:0] kind;
  logic inta, inta_n, wz, wz_n, hcyc, hcyc_n, hack, hack_n, rhalt, rhalt_n;
  logic skip, done, taken;

  always_comb begin
    ln = d_len[1:0];
    ty = 3'd0;
    for (int i = 1; i < NUM_M; i++) begin
      if (m == MW'(i + 1)) begin
        ln = d_len[2*i +: 2];
        ty = d_type[3*(i-1) +: 3];
      end
    end
  end

  assign kind   = (m == MW'(1)) ? (inta ? K_INTA : K_FETCH) :
                  hcyc ? K_HALT :
                  (ty == 3'd0 || ty == 3'd7) ? K_INT : ({1'b0, ty} + 4'd1);
  assign last_t = hcyc ? S_T2 : (ln == 2'd0) ? 3'd3 : (ln == 2'd1) ? 3'd4 : 3'd5;
  assign skip   = d_cond && !d_cond_ok && (m == (d_skip_hi ? MW'(3) : MW'(1)));
  assign done   = (m >= d_ncyc) || skip || (m == MW'(NUM_M));
  assign taken  = d_xfer && !(d_cond && !d_cond_ok);

  always_comb begin
    m_n = m; t_n = t; inta_n = inta; wz_n = wz; hcyc_n = hcyc; rhalt_n = rhalt;
    case (t)
      S_HOLD: if (!hold_req) begin
        t_n = rhalt ? S_HALT : S_T1;
        rhalt_n = 1'b0;
      end
      S_HALT: if (int_req) begin
        m_n = MW'(1); t_n = S_T1; inta_n = 1'b1; wz_n = 1'b0;
      end else if (hold_req) begin
        t_n = S_HOLD; rhalt_n = 1'b1;
      end
      S_WAIT: if (ready) t_n = S_T3;
      default: begin
        if (hcyc && t == S_T2) begin
          t_n = S_HALT; hcyc_n = 1'b0;
        end else if (t == S_T2 && kind != K_INT && !ready) begin
          t_n = S_WAIT;
        end else if (t < last_t) begin
          t_n = t + 3'd1;
        end else begin
          if (m == MW'(1) && d_halt) begin
            m_n = MW'(2); hcyc_n = 1'b1;
          end else if (done) begin
            m_n = MW'(1); inta_n = int_req; wz_n = taken;
          end else begin
            m_n = m + MW'(1);
          end
          t_n = hold_req ? S_HOLD : S_T1;
        end
      end
    endcase
    hack_n = (t_n == S_HOLD) ||
             (hold_req && kind == K_INT && !hcyc && m_n == m && t_n >= S_T2 && t_n <= 3'd5);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m <= MW'(1); t <= S_T1; inta <= 1'b0; wz <= 1'b0;
      hcyc <= 1'b0; hack <= 1'b0; rhalt <= 1'b0;
    end else begin
      m <= m_n; t <= t_n; inta <= inta_n; wz <= wz_n;
      hcyc <= hcyc_n; hack <= hack_n; rhalt <= rhalt_n;
    end
  end

  assign m_state  = m;
  assign t_state  = t;
  assign sync     = (t == S_T1) && (kind != K_INT);
  assign status   = sync ? kind : 4'd0;
  assign hold_ack = hack;
  assign halted   = (t == S_HALT) || (t == S_HOLD && rhalt);

  always_comb begin
    if (hack) addr_sel = A_HIZ;
    else if (t == S_HALT) addr_sel = A_PC;
    else case (kind)
      K_FETCH:             addr_sel = wz ? A_WZ : A_PC;
      4'd3, 4'd4, 4'd5:    addr_sel = A_PTR;
      4'd6, 4'd7:          addr_sel = A_PORT;
      default:             addr_sel = A_PC;
    endcase
  end
endmodule

// File: rtl/mcycle_seq_chk.sv
module mcycle_seq_chk #(
  parameter int NUM_M = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ready,
  input logic                       hold_req,
  input logic                       int_req,
  input logic [$clog2(NUM_M+1)-1:0] m_state,
  input logic [2:0]                 t_state,
  input logic                       sync,
  input logic [3:0]                 status,
  input logic                       hold_ack,
  input logic                       halted,
  input logic [2:0]                 addr_sel
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (m_state == 1 && t_state == 3'd1 && !hold_ack && !halted));
  p_sync_only_t1_r3: assert property (@(posedge clk) disable iff (rst)
    sync |-> t_state == 3'd1);
  p_m1_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    (sync && m_state == 1) |-> (status == 4'd1 || status == 4'd8));
  p_wait_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (t_state == 3'd6 && ready) |=> t_state == 3'd3);
  p_wait_stay_r4: assert property (@(posedge clk) disable iff (rst)
    (t_state == 3'd6 && !ready) |=> t_state == 3'd6);
  p_wait_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(t_state == 3'd6) |-> $past(t_state) == 3'd2);
  p_halt_stay_r9: assert property (@(posedge clk) disable iff (rst)
    (t_state == 3'd7 && !int_req && !hold_req) |=> t_state == 3'd7);
  p_int_exit_r10: assert property (@(posedge clk) disable iff (rst)
    (t_state == 3'd7 && int_req) |=> (m_state == 1 && t_state == 3'd1 && status == 4'd8));
  p_hold_float_r11: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> addr_sel == 3'd4);
  p_hold_state_ack_r11: assert property (@(posedge clk) disable iff (rst)
    t_state == 3'd0 |-> hold_ack);
endmodule

bind mcycle_seq mcycle_seq_chk #(.NUM_M(NUM_M)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .hold_req(hold_req), .int_req(int_req),
  .m_state(m_state), .t_state(t_state), .sync(sync), .status(status),
  .hold_ack(hold_ack), .halted(halted), .addr_sel(addr_sel)
);

// File: tb/mcycle_seq_tb.sv
`timescale 1ns/1ps
module mcycle_seq_tb;
  localparam int NUM_M = 5;
  localparam int MW = $clog2(NUM_M + 1);

  logic clk = 1'b0, rst = 1'b1, ready = 1'b1, hold_req = 1'b0, int_req = 1'b0;
  logic [MW-1:0] d_ncyc = '0;
  logic [2*NUM_M-1:0] d_len = '0;
  logic [3*(NUM_M-1)-1:0] d_type = '0;
  logic d_cond = 1'b0, d_cond_ok = 1'b0, d_skip_hi = 1'b0, d_xfer = 1'b0, d_halt = 1'b0;
  logic [MW-1:0] m_state;
  logic [2:0] t_state, addr_sel;
  logic sync, hold_ack, halted;
  logic [3:0] status;

  int checks = 0, errors = 0;
  int em, et, nm, nt;
  bit ei, ew, eh, ea, er, ni, nw, nh, na, nr;

  always #2.5 clk = ~clk;

  mcycle_seq #(.NUM_M(NUM_M)) u_dut (
    .clk(clk), .rst(rst), .ready(ready), .hold_req(hold_req), .int_req(int_req),
    .d_ncyc(d_ncyc), .d_len(d_len), .d_type(d_type), .d_cond(d_cond),
    .d_cond_ok(d_cond_ok), .d_skip_hi(d_skip_hi), .d_xfer(d_xfer), .d_halt(d_halt),
    .m_state(m_state), .t_state(t_state), .sync(sync), .status(status),
    .hold_ack(hold_ack), .halted(halted), .addr_sel(addr_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int e_kind();
    int ty;
    if (em == 1) return ei ? 8 : 1;
    if (eh) return 9;
    ty = (em >= 2 && em <= NUM_M) ? int'(d_type[3*(em-2) +: 3]) : 0;
    return (ty == 0 || ty == 7) ? 0 : ty + 1;
  endfunction

  function automatic int e_addr();
    int k = e_kind();
    if (ea) return 4;
    if (et == 7) return 0;
    if (k == 1) return ew ? 1 : 0;
    if (k >= 3 && k <= 5) return 3;
    if (k == 6 || k == 7) return 2;
    return 0;
  endfunction

  function automatic string e_tag();
    int k = e_kind();
    if (et == 0) return "R11";
    if (et == 7) return "R9";
    if (et == 6) return "R4";
    if (k == 8) return "R10";
    if (k == 9) return "R9";
    if (k == 0) return "R5";
    if (k == 6 || k == 7) return "R8";
    if (k == 1 && ew) return "R7";
    if (k >= 2) return "R12";
    return "R2";
  endfunction

  task automatic compare();
    int k = e_kind();
    bit es = (et == 1) && (k != 0);
    int est = es ? k : 0;
    bit eh2 = (et == 7) || (et == 0 && er);
    bit ok = int'(m_state) == em && int'(t_state) == et && sync == es &&
             int'(status) == est && hold_ack == ea && halted == eh2 &&
             int'(addr_sel) == e_addr();
    chk(ok, e_tag(), int'({m_state, t_state, sync, status, hold_ack, halted, addr_sel}),
        ((em * 8 + et) * 2 + int'(es)) * 1024 + est * 64 + int'(ea) * 16 + int'(eh2) * 8 + e_addr());
  endtask

  task automatic model_next();
    int k = e_kind();
    int lt, c;
    bit skip, done;
    nm = em; nt = et; ni = ei; nw = ew; nh = eh; nr = er;
    if (rst) begin
      nm = 1; nt = 1; ni = 0; nw = 0; nh = 0; na = 0; nr = 0;
      return;
    end
    c = int'(d_len[2*(em-1) +: 2]);
    lt = eh ? 2 : (3 + c > 5 ? 5 : 3 + c);
    skip = d_cond && !d_cond_ok && (em == (d_skip_hi ? 3 : 1));
    done = em >= int'(d_ncyc) || skip || em == NUM_M;
    if (et == 0) begin
      if (!hold_req) begin nt = er ? 7 : 1; nr = 0; end
    end else if (et == 7) begin
      if (int_req) begin nm = 1; nt = 1; ni = 1; nw = 0; end
      else if (hold_req) begin nt = 0; nr = 1; end
    end else if (et == 6) begin
      if (ready) nt = 3;
    end else if (eh && et == 2) begin
      nt = 7; nh = 0;
    end else if (et == 2 && k != 0 && !ready) begin
      nt = 6;
    end else if (et < lt) begin
      nt = et + 1;
    end else begin
      if (em == 1 && d_halt) begin nm = 2; nh = 1; end
      else if (done) begin nm = 1; ni = int_req; nw = d_xfer && !(d_cond && !d_cond_ok); end
      else nm = em + 1;
      nt = hold_req ? 0 : 1;
    end
    na = (nt == 0) || (hold_req && k == 0 && !eh && nm == em && nt >= 2 && nt <= 5);
  endtask

  task automatic step();
    model_next();
    @(posedge clk);
    em = nm; et = nt; ei = ni; ew = nw; eh = nh; ea = na; er = nr;
    @(negedge clk);
    compare();
  endtask

  task automatic to_next_t1();
    int g = 0;
    step();
    while (t_state != 3'd1 && g < 60) begin step(); g++; end
  endtask

  task automatic clr_desc();
    d_ncyc = MW'(1); d_len = '0; d_type = '0; d_cond = 0; d_cond_ok = 0;
    d_skip_hi = 0; d_xfer = 0; d_halt = 0;
  endtask

  task automatic rand_desc();
    d_halt = ($urandom % 20) == 0;
    d_ncyc = d_halt ? MW'(1) : MW'(1 + $urandom % NUM_M);
    d_len = (2*NUM_M)'($urandom);
    d_type = (3*(NUM_M-1))'($urandom);
    d_cond = ($urandom % 4) == 0;
    d_cond_ok = 1'($urandom % 2);
    d_skip_hi = 1'($urandom % 2);
    d_xfer = ($urandom % 3) == 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(); step();
    rst = 1'b0;
    // R1: reset state
    chk(m_state == 1 && t_state == 3'd1 && sync && status == 4'd1 && addr_sel == 3'd0
        && !hold_ack && !halted, "R1", int'(t_state), 1);

    // R2/R3/R12/R4: 4-state M1, then a write cycle with waits
    clr_desc(); d_ncyc = MW'(2); d_len[1:0] = 2'd1; d_type[2:0] = 3'd2;
    step(); step(); step();
    chk(t_state == 3'd4, "R2", int'(t_state), 4);
    step();
    chk(m_state == 2 && t_state == 3'd1 && sync && status == 4'd3, "R3", int'(status), 3);
    chk(addr_sel == 3'd3, "R12", int'(addr_sel), 3);
    step(); ready = 1'b0; step();
    chk(t_state == 3'd6, "R4", int'(t_state), 6);
    step();
    chk(t_state == 3'd6, "R4", int'(t_state), 6);
    ready = 1'b1; step();
    chk(t_state == 3'd3, "R4", int'(t_state), 3);
    step();
    chk(m_state == 1 && t_state == 3'd1, "R2", int'(m_state), 1);

    // R6: failed condition, early skip
    clr_desc(); d_ncyc = MW'(3); d_cond = 1; d_type = (3*(NUM_M-1))'(12'h009);
    step(); step(); step();
    chk(m_state == 1 && t_state == 3'd1, "R6", int'(m_state), 1);

    // R6: failed condition, late skip; R12 read from PC
    clr_desc(); d_ncyc = MW'(5); d_cond = 1; d_skip_hi = 1; d_type = (3*(NUM_M-1))'(12'h909);
    to_next_t1();
    chk(addr_sel == 3'd0 && status == 4'd2, "R12", int'(addr_sel), 0);
    to_next_t1(); to_next_t1();
    chk(m_state == 1 && t_state == 3'd1, "R6", int'(m_state), 1);

    // R7: taken transfer
    clr_desc(); d_xfer = 1;
    to_next_t1();
    chk(addr_sel == 3'd1 && status == 4'd1, "R7", int'(addr_sel), 1);

    // R8: output cycle
    clr_desc(); d_ncyc = MW'(2); d_type[2:0] = 3'd6;
    to_next_t1();
    chk(m_state == 2 && addr_sel == 3'd2 && status == 4'd7, "R8", int'(addr_sel), 2);
    to_next_t1();

    // R5: internal cycles
    clr_desc(); d_ncyc = MW'(3);
    to_next_t1();
    chk(m_state == 2 && !sync && status == 4'd0, "R5", int'(sync), 0);
    ready = 1'b0; hold_req = 1'b1; step();
    chk(t_state == 3'd2 && hold_ack && addr_sel == 3'd4, "R5", int'(addr_sel), 4);
    step();
    chk(t_state == 3'd3, "R5", int'(t_state), 3);
    hold_req = 1'b0; step();
    chk(m_state == 3 && t_state == 3'd1 && !hold_ack, "R5", int'(hold_ack), 0);
    ready = 1'b1; to_next_t1();

    // R11: hold at a cycle boundary
    clr_desc(); hold_req = 1'b1;
    step(); step(); step();
    chk(t_state == 3'd0 && hold_ack && addr_sel == 3'd4, "R11", int'(t_state), 0);
    step();
    chk(t_state == 3'd0, "R11", int'(t_state), 0);
    hold_req = 1'b0; step();
    chk(m_state == 1 && t_state == 3'd1 && !hold_ack, "R11", int'(t_state), 1);

    // R9/R11/R10: halt, hold from halt, interrupt exit
    clr_desc(); d_halt = 1;
    step(); step(); step();
    chk(m_state == 2 && sync && status == 4'd9, "R9", int'(status), 9);
    step(); step();
    chk(t_state == 3'd7 && halted, "R9", int'(t_state), 7);
    step(); step(); step();
    chk(t_state == 3'd7 && halted, "R9", int'(t_state), 7);
    hold_req = 1'b1; step();
    chk(t_state == 3'd0 && halted && hold_ack, "R11", int'(halted), 1);
    hold_req = 1'b0; step();
    chk(t_state == 3'd7, "R11", int'(t_state), 7);
    int_req = 1'b1; step();
    chk(m_state == 1 && t_state == 3'd1 && status == 4'd8 && addr_sel == 3'd0, "R10", int'(status), 8);
    int_req = 1'b0; clr_desc();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      ready = ($urandom % 4) != 0;
      hold_req = hold_req ? (($urandom % 4) != 0) : (($urandom % 25) == 0);
      int_req = ($urandom % 30) == 0;
      if (em == 1 && et == 1) rand_desc();
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule